// File: doc/BRIEF.md
# Segmented DAC Switch-Control Encoder

This block turns a binary code word into the switch controls of a segmented current-steering converter. The upper field of the word selects how many equal-weight unit cells are on. The lower field drives binary-weighted cells bit for bit. The unit-cell requests are first expressed as a thermometer count. They are then scattered onto physical cell positions in a centre-outward pattern. With this pattern, gradient errors cancel between neighbouring cells instead of building up along a line.

The thermometer decode takes one register stage. The binary field goes through a delay register of the same depth, so both halves arrive together. A single output register then launches every control on the same clock edge. A new word is taken only while the valid strobe is high. When the strobe is low, the controls keep their last value.

Top module: `segdac_ctrl_enc`

## Requirements
- R1: While reset is high, and after it is released until the first accepted word reaches the output, every bit of `unit_en` and `bin_en` is 0.
- R2: The number of asserted bits in `unit_en` equals the value of the upper field `code[CODE_W-1:LSB_W]`.
- R3: Unit cells fill in a symmetric order. Switch step k (k = 0, 1, 2, …) sets bit c + ceil(k/2)·(−1)^k of `unit_en`, where c = (NUM_UNITS−1)/2. For the default 15 cells, c = 7: a field value of 1 sets bit 7 only, 2 sets bits 6 and 7, and 3 sets bits 6 to 8.
- R4: `bin_en[i]` equals bit i of the lower field `code[LSB_W-1:0]`, so bit i carries weight 2^i.
- R5: A word sampled with `code_vld` high on clock edge N appears on both outputs after edge N+1. Both outputs update on that same edge.
- R6: A word presented with `code_vld` low has no effect: both outputs keep their previous value.
- R7: The sum of 2^LSB_W for each asserted unit bit, plus the value of `bin_en`, equals the accepted input code.
- R8: Code 0 gives all controls off. The all-ones code gives all NUM_UNITS unit bits set and every `bin_en` bit set.
- R9: When the upper field grows from one accepted word to the next, every unit bit that was already on stays on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Accept strobe for `code` |
| code | input | MSB_W+LSB_W | Binary code word |
| unit_en | output | 2^MSB_W−1 | Registered unit-cell enables, in physical position order |
| bin_en | output | LSB_W | Registered binary-weighted cell enables |

## Verification
The bench builds the block with the default 4+4 split. At that size all 256 codes can be swept exhaustively, so every thermometer count from 0 to 15 is seen, along with every step of the odd-length, centre-outward fill. Random words are mixed in, with the strobe dropped in bursts while the data keeps changing. These bursts show the two-cycle latency and the hold behaviour against a scoreboard. Rising-field sequences check that cells which are already on stay on.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  // Physical position of the k-th unit cell to switch on, centre outward.
  function automatic int sym_pos(input int k, input int n_units);
    int centre;
    int step;
    centre = (n_units - 1) / 2;
    step   = (k + 1) / 2;
    if ((k % 2) == 1) return centre - step;
    else              return centre + step;
  endfunction

endpackage

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
  parameter int MSB_W     = 4,
  parameter int NUM_UNITS = (1 << MSB_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic [MSB_W-1:0]     msb_i,
  output logic                 vld_o,
  output logic [NUM_UNITS-1:0] therm_o
);

  logic [NUM_UNITS-1:0] therm_d;

  generate
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_cmp
      assign therm_d[i] = (msb_i > MSB_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      therm_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) therm_o <= therm_d;
    end
  end

  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> ($countones(therm_o) == int'($past(msb_i)))); // R2

endmodule

// File: rtl/segdac_lsb_delay.sv
module segdac_lsb_delay #(
  parameter int LSB_W = 4,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [LSB_W-1:0] lsb_i,
  output logic             vld_o,
  output logic [LSB_W-1:0] lsb_o
);

  logic [DEPTH-1:0]            vq;
  logic [DEPTH-1:0][LSB_W-1:0] dq;

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0;
      dq <= '0;
    end else begin
      vq[0] <= vld_i;
      if (vld_i) dq[0] <= lsb_i;
      for (int s = 1; s < DEPTH; s++) begin
        vq[s] <= vq[s-1];
        if (vq[s-1]) dq[s] <= dq[s-1];
      end
    end
  end

  assign vld_o = vq[DEPTH-1];
  assign lsb_o = dq[DEPTH-1];

endmodule

// File: rtl/segdac_sym_map.sv
module segdac_sym_map
  import segdac_pkg::*;
#(
  parameter int NUM_UNITS = 15
) (
  input  logic [NUM_UNITS-1:0] therm_i,
  output logic [NUM_UNITS-1:0] unit_o
);

  generate
    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_place
      localparam int POS = sym_pos(k, NUM_UNITS);
      assign unit_o[POS] = therm_i[k];
    end
  endgenerate

endmodule

// File: rtl/segdac_out_reg.sv
module segdac_out_reg #(
  parameter int NUM_UNITS = 15,
  parameter int LSB_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 unit_vld_i,
  input  logic                 bin_vld_i,
  input  logic [NUM_UNITS-1:0] unit_i,
  input  logic [LSB_W-1:0]     bin_i,
  output logic [NUM_UNITS-1:0] unit_o,
  output logic [LSB_W-1:0]     bin_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_o <= '0;
      bin_o  <= '0;
    end else begin
      if (unit_vld_i) unit_o <= unit_i;
      if (bin_vld_i)  bin_o  <= bin_i;
    end
  end

  AST_SEGMENTS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    unit_vld_i == bin_vld_i); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !unit_vld_i |=> ($stable(unit_o) && $stable(bin_o))); // R6

endmodule

// File: rtl/segdac_ctrl_enc.sv
module segdac_ctrl_enc #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       code_vld,
  input  logic [MSB_W+LSB_W-1:0]     code,
  output logic [(1<<MSB_W)-2:0]      unit_en,
  output logic [LSB_W-1:0]           bin_en
);

  localparam int CODE_W    = MSB_W + LSB_W;
  localparam int NUM_UNITS = (1 << MSB_W) - 1;
  localparam int DEC_LAT   = 1;

  logic                 therm_vld;
  logic [NUM_UNITS-1:0] therm;
  logic [NUM_UNITS-1:0] placed;
  logic                 lsb_vld;
  logic [LSB_W-1:0]     lsb_dly;

  segdac_therm_dec #(.MSB_W(MSB_W), .NUM_UNITS(NUM_UNITS)) u_dec (
    .clk(clk), .rst(rst), .vld_i(code_vld), .msb_i(code[CODE_W-1:LSB_W]),
    .vld_o(therm_vld), .therm_o(therm)
  );

  segdac_lsb_delay #(.LSB_W(LSB_W), .DEPTH(DEC_LAT)) u_dly (
    .clk(clk), .rst(rst), .vld_i(code_vld), .lsb_i(code[LSB_W-1:0]),
    .vld_o(lsb_vld), .lsb_o(lsb_dly)
  );

  segdac_sym_map #(.NUM_UNITS(NUM_UNITS)) u_map (
    .therm_i(therm), .unit_o(placed)
  );

  segdac_out_reg #(.NUM_UNITS(NUM_UNITS), .LSB_W(LSB_W)) u_out (
    .clk(clk), .rst(rst), .unit_vld_i(therm_vld), .bin_vld_i(lsb_vld),
    .unit_i(placed), .bin_i(lsb_dly), .unit_o(unit_en), .bin_o(bin_en)
  );

  // Edges seen since reset, saturating at 2, so that $past(...,2) stays within the run.
  logic [1:0] run_age;
  logic       rst_seen;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)                run_age <= 2'd0;
    else if (run_age != 2'd2) run_age <= run_age + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      AST_RESET_CLEAR: assert (unit_en == '0 && bin_en == '0); // R1
    end
  end

  AST_LATENCY_BIN: assert property (@(posedge clk) disable iff (rst)
    (run_age == 2'd2 && $past(code_vld, 2)) |->
      (bin_en == $past(code[LSB_W-1:0], 2))); // R4

  AST_LATENCY_UNITS: assert property (@(posedge clk) disable iff (rst)
    (run_age == 2'd2 && $past(code_vld, 2)) |->
      ($countones(unit_en) == int'($past(code[CODE_W-1:LSB_W], 2)))); // R5

  AST_CENTRE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (unit_en != '0) |-> unit_en[(NUM_UNITS-1)/2]); // R3

endmodule

// File: tb/sim_segdac_ctrl_enc.sv
module sim_segdac_ctrl_enc;
  localparam int MSB_W = 4;
  localparam int LSB_W = 4;
  localparam int CW    = MSB_W + LSB_W;
  localparam int NU    = (1 << MSB_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          code_vld = 1'b0;
  logic [CW-1:0] code = '0;
  logic [NU-1:0] unit_en;
  logic [LSB_W-1:0] bin_en;

  segdac_ctrl_enc #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u0 (
    .clk(clk), .rst(rst), .code_vld(code_vld), .code(code),
    .unit_en(unit_en), .bin_en(bin_en)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic v; logic [CW-1:0] c; } item_t;
  item_t q[$];
  logic [CW-1:0] exp_code = '0;
  logic [NU-1:0] prev_units = '0;
  int            prev_msb = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, expv);
    end
  endtask

  function automatic logic [NU-1:0] model_units(input int m);
    logic [NU-1:0] v;
    int c;
    v = '0;
    c = (NU - 1) / 2;
    for (int k = 0; k < m; k++) begin
      if (k % 2 == 1) v[c - (k + 1) / 2] = 1'b1;
      else            v[c + k / 2]       = 1'b1;
    end
    return v;
  endfunction

  task automatic check_state();
    int m, l, sum;
    logic [NU-1:0] eu;
    m = int'(exp_code[CW-1:LSB_W]);
    l = int'(exp_code[LSB_W-1:0]);
    eu = model_units(m);
    chk(unit_en == eu, "R3 R5 R6 unit vector", int'(unit_en), int'(eu));
    chk($countones(unit_en) == m, "R2 unit count", $countones(unit_en), m);
    chk(int'(bin_en) == l, "R4 binary enables", int'(bin_en), l);
    sum = $countones(unit_en) * (1 << LSB_W) + int'(bin_en);
    chk(sum == int'(exp_code), "R7 weighted sum", sum, int'(exp_code));
    if (m > prev_msb)
      chk((prev_units & ~unit_en) == '0, "R9 cells stay on", int'(unit_en), int'(prev_units));
    prev_units = unit_en;
    prev_msb   = m;
  endtask

  // Monitor: scoreboard pop and compare, mid-cycle.
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.v) exp_code = it.c;
      end
      check_state();
    end
  end

  task automatic send(input logic v, input logic [CW-1:0] c);
    @(negedge clk);
    code_vld = v;
    code     = c;
    q.push_back('{cyc + 2, v, c});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    code_vld = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    chk(unit_en == '0, "R1 unit enables in reset", int'(unit_en), 0);
    chk(bin_en == '0, "R1 binary enables in reset", int'(bin_en), 0);
    exp_code   = '0;
    prev_units = '0;
    prev_msb   = 0;
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle after reset keeps everything off
    repeat (3) send(1'b0, 8'hA5);
    // R5: single word, hold afterwards
    send(1'b1, 8'h3C);
    repeat (4) send(1'b0, 8'hFF);
    // R8: full scale then zero
    send(1'b1, '1);
    send(1'b0, 8'h00);
    send(1'b0, 8'h00);
    @(negedge clk);
    chk(unit_en == '1, "R8 full scale units", int'(unit_en), int'({NU{1'b1}}));
    chk(bin_en == '1, "R8 full scale binary", int'(bin_en), int'({LSB_W{1'b1}}));
    send(1'b1, 8'h00);
    send(1'b0, 8'hFF);
    send(1'b0, 8'hFF);
    @(negedge clk);
    chk(unit_en == '0 && bin_en == '0, "R8 zero code", int'(unit_en), 0);
    // R3 R9: exhaustive rising sweep, back to back
    for (int c = 0; c < (1 << CW); c++) send(1'b1, CW'(c));
    // R6: strobe-gated sweep with changing data in the gaps
    for (int c = (1 << CW) - 1; c >= 0; c--) begin
      send(1'b1, CW'(c));
      send(1'b0, CW'(c ^ 8'h5A));
    end
    // Random mix
    for (int i = 0; i < 600; i++) send(1'($urandom_range(0, 2) != 0), CW'($urandom));
    // Reset in mid-stream clears the pipeline
    send(1'b1, 8'hE7);
    do_reset();
    repeat (3) send(1'b0, 8'h99);
    repeat (4) send(1'b0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule